// File: doc/BRIEF.md
# Three-Plane Character Row Pixel Serializer

This block turns bitmap memory into a pixel stream for one character row of a colour raster display. At the start of each row a display timing controller supplies a character memory address, a raster line number and the number of characters on the line. From those the block forms a 13-bit plane offset. For each character it reads one byte at the same offset from three bitplanes (red, blue and green) and shifts the byte set out as eight 3-bit colour indices. A downstream palette turns those indices into colours.

Two green planes exist. A select bit, captured once at the start of each row, chooses which one the green read targets. The block drives that choice to the memory as its own output. Reads run one character ahead of the pixels, so there is no gap at character boundaries. A blanking input forces the index to zero.

Top module: `tri_plane_row_ser`

## Requirements
- R1: After reset the pixel index is 0 and stays 0 until a row is started.
- R2: A row is started by `row_start` high on a clock edge. The plane offset taken at that edge is ((ma × 4) + (ra × 32)) modulo 8192.
- R3: Character c of the row is read at (offset + c) modulo 8192. While the pixels of character c are being shown, `rd_off` already holds (offset + c + 1) modulo 8192.
- R4: Each character gives 8 pixels, starting with data bit 7. The index has blue in bit 2, green in bit 1 and red in bit 0.
- R5: `gplane_sel` takes the value of `green_alt` at the row-start edge (1 = alternate green plane, 0 = normal green plane). Changing `green_alt` during a row has no effect on that row.
- R6: A row with count N yields exactly 8N pixels, after which the index is 0. A count of 0 yields no pixels.
- R7: While `disp_en` is low, the pixel index is 0 in that same cycle.
- R8: A `row_start` during a row abandons the old row. The index is 0 in the cycle after that edge, and the new row then runs in full.
- R9: The first pixel appears in the second cycle after the row-start edge. The 8N pixels follow in consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_start | input | 1 | Starts a new character row |
| ma | input | 14 | Character memory address from timing controller |
| ra | input | 5 | Raster line within the character row |
| char_count | input | 8 | Characters on this row |
| green_alt | input | 1 | Selects the alternate green plane for the next row |
| disp_en | input | 1 | Display enable; low blanks the index |
| red_data | input | 8 | Red plane byte at `rd_off` |
| blue_data | input | 8 | Blue plane byte at `rd_off` |
| green_data | input | 8 | Byte at `rd_off` from the green plane named by `gplane_sel` |
| rd_off | output | 13 | Plane read offset shared by all planes |
| gplane_sel | output | 1 | Green plane chosen for this row |
| pix_idx | output | 3 | Colour index {blue, green, red} |

## Verification
A bad offset or a stuck address counter shows up in the first pixel of the affected character as an index taken from the wrong byte. A miscounted character or dot counter shows up at the next character boundary as a shifted pixel or a row of the wrong length. The bench compares every pixel of every row, and `rd_off` at each character start, against values derived from address-keyed plane functions, so a fault is caught within eight cycles of where it arises. Rows near the top of the 13-bit space, empty rows, aborted rows, green toggles during a row and random blanking cover the edge cases.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int TRS_MA_W   = 14;
  localparam int TRS_RA_W   = 5;
  localparam int TRS_OFF_W  = 13;
  localparam int TRS_CNT_W  = 8;
  localparam int TRS_BYTE_W = 8;
  localparam int TRS_NPLANE = 3;
  // plane slot within the colour index
  localparam int SLOT_RED = 0;
  localparam int SLOT_GRN = 1;
  localparam int SLOT_BLU = 2;
endpackage

// File: rtl/trs_ctrl.sv
module trs_ctrl #(
  parameter int CNT_W = 8,
  parameter int DOT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic [CNT_W-1:0] char_count,
  output logic             load,
  output logic             busy
);
  localparam logic [DOT_W-1:0] DOT_LAST = '1;

  logic             prime_q, prime_d;
  logic             busy_q,  busy_d;
  logic [DOT_W-1:0] dot_q,   dot_d;
  logic [CNT_W-1:0] left_q,  left_d;

  always_comb begin
    prime_d = prime_q;
    busy_d  = busy_q;
    dot_d   = dot_q;
    left_d  = left_q;
    load    = 1'b0;
    if (row_start) begin
      prime_d = (char_count != '0);
      busy_d  = 1'b0;
      left_d  = char_count;
      dot_d   = '0;
    end else if (prime_q) begin
      prime_d = 1'b0;
      busy_d  = 1'b1;
      left_d  = left_q - CNT_W'(1);
      dot_d   = '0;
      load    = 1'b1;
    end else if (busy_q) begin
      if (dot_q == DOT_LAST) begin
        dot_d = '0;
        if (left_q != '0) begin
          load   = 1'b1;
          left_d = left_q - CNT_W'(1);
        end else begin
          busy_d = 1'b0;
        end
      end else begin
        dot_d = dot_q + DOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q <= 1'b0;
      busy_q  <= 1'b0;
      dot_q   <= '0;
      left_q  <= '0;
    end else begin
      prime_q <= prime_d;
      busy_q  <= busy_d;
      dot_q   <= dot_d;
      left_q  <= left_d;
    end
  end

  assign busy = busy_q;

  a_r9_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prime_q, busy_q}));
  a_r6_empty_row: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start && char_count == '0) |=> (!busy_q && !prime_q));
  a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !row_start && dot_q != DOT_LAST) |=> busy_q);
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> !busy_q);
endmodule

// File: rtl/trs_addr.sv
module trs_addr #(
  parameter int MA_W  = 14,
  parameter int RA_W  = 5,
  parameter int OFF_W = 13,
  parameter int MA_SH = 2,
  parameter int RA_SH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic             load,
  input  logic [MA_W-1:0]  ma,
  input  logic [RA_W-1:0]  ra,
  input  logic             green_alt,
  output logic [OFF_W-1:0] rd_off,
  output logic             gsel
);
  localparam int SUM_W = ((MA_W + MA_SH > RA_W + RA_SH) ? MA_W + MA_SH : RA_W + RA_SH) + 1;

  logic [OFF_W-1:0] base;
  logic [OFF_W-1:0] off_q, off_d;
  logic             gsel_q, gsel_d;

  assign base = OFF_W'((SUM_W'(ma) << MA_SH) + (SUM_W'(ra) << RA_SH));

  always_comb begin
    off_d  = off_q;
    gsel_d = gsel_q;
    if (row_start) begin
      off_d  = base;
      gsel_d = green_alt;
    end else if (load) begin
      off_d  = off_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      gsel_q <= 1'b0;
    end else begin
      off_q  <= off_d;
      gsel_q <= gsel_d;
    end
  end

  assign rd_off = off_q;
  assign gsel   = gsel_q;

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !row_start) |=> rd_off == OFF_W'($past(rd_off) + OFF_W'(1)));
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> gsel == $past(green_alt));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !row_start |=> $stable(gsel));
endmodule

// File: rtl/trs_plane_shift.sv
module trs_plane_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = din;
    else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[W-1];

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sh_q == $past(din));
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> msb == $past(sh_q[W-2]));
endmodule

// File: rtl/tri_plane_row_ser.sv
module tri_plane_row_ser
  import trs_pkg::*;
#(
  parameter int MA_W   = TRS_MA_W,
  parameter int RA_W   = TRS_RA_W,
  parameter int OFF_W  = TRS_OFF_W,
  parameter int CNT_W  = TRS_CNT_W,
  parameter int BYTE_W = TRS_BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  row_start,
  input  logic [MA_W-1:0]       ma,
  input  logic [RA_W-1:0]       ra,
  input  logic [CNT_W-1:0]      char_count,
  input  logic                  green_alt,
  input  logic                  disp_en,
  input  logic [BYTE_W-1:0]     red_data,
  input  logic [BYTE_W-1:0]     blue_data,
  input  logic [BYTE_W-1:0]     green_data,
  output logic [OFF_W-1:0]      rd_off,
  output logic                  gplane_sel,
  output logic [TRS_NPLANE-1:0] pix_idx
);
  localparam int DOT_W = $clog2(BYTE_W);

  logic                  load, busy;
  logic [BYTE_W-1:0]     plane_din [TRS_NPLANE];
  logic [TRS_NPLANE-1:0] msb;

  trs_ctrl #(.CNT_W(CNT_W), .DOT_W(DOT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .row_start(row_start),
    .char_count(char_count), .load(load), .busy(busy));

  trs_addr #(.MA_W(MA_W), .RA_W(RA_W), .OFF_W(OFF_W), .MA_SH(2), .RA_SH(5)) addr_i (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .load(load),
    .ma(ma), .ra(ra), .green_alt(green_alt),
    .rd_off(rd_off), .gsel(gplane_sel));

  assign plane_din[SLOT_RED] = red_data;
  assign plane_din[SLOT_GRN] = green_data;
  assign plane_din[SLOT_BLU] = blue_data;

  for (genvar p = 0; p < TRS_NPLANE; p++) begin : g_plane
    trs_plane_shift #(.W(BYTE_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(busy),
      .din(plane_din[p]), .msb(msb[p]));
  end

  assign pix_idx = (busy && disp_en) ? msb : '0;
endmodule

// File: tb/tri_plane_row_ser_tb_top.sv
module tri_plane_row_ser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        row_start;
  logic [13:0] ma;
  logic [4:0]  ra;
  logic [7:0]  char_count;
  logic        green_alt, disp_en;
  logic [7:0]  red_data, blue_data, green_data;
  logic [12:0] rd_off;
  logic        gplane_sel;
  logic [2:0]  pix_idx;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] f_red(int a);  return 8'((a * 37 + 11) ^ (a >> 3)); endfunction
  function automatic logic [7:0] f_blu(int a);  return 8'((a * 91) ^ (a >> 1) ^ 8'h5A); endfunction
  function automatic logic [7:0] f_gn(int a);   return 8'(a * 13 + (a >> 4)); endfunction
  function automatic logic [7:0] f_ga(int a);   return 8'(~(a * 29) ^ (a >> 2)); endfunction
  function automatic int exp_off(int m, int r); return ((m * 4) + (r * 32)) & 16'h1FFF; endfunction

  assign red_data   = f_red(int'(rd_off));
  assign blue_data  = f_blu(int'(rd_off));
  assign green_data = gplane_sel ? f_ga(int'(rd_off)) : f_gn(int'(rd_off));

  tri_plane_row_ser dut_i (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .ma(ma), .ra(ra),
    .char_count(char_count), .green_alt(green_alt), .disp_en(disp_en),
    .red_data(red_data), .blue_data(blue_data), .green_data(green_data),
    .rd_off(rd_off), .gplane_sel(gplane_sel), .pix_idx(pix_idx));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Starts a row; checks up to 'limit' pixels (all when limit < 0).
  task automatic run_row(int m, int r, int n, bit galt, int limit, bit rand_de);
    int off = exp_off(m, r);
    int total = 8 * n;
    int upto = (limit >= 0 && limit < total) ? limit : total;
    row_start = 1'b1; ma = 14'(m); ra = 5'(r); char_count = 8'(n); green_alt = galt;
    @(negedge clk);
    row_start = 1'b0; disp_en = 1'b1;
    #1;
    chk("R8 idle cycle after row start", int'(pix_idx), 0);
    chk("R5 green select captured", int'(gplane_sel), int'(galt));
    chk("R2 offset latched", int'(rd_off), off);
    for (int k = 0; k < upto; k++) begin
      @(negedge clk);
      disp_en = rand_de ? ($urandom_range(0, 3) != 0) : 1'b1;
      green_alt = $urandom_range(0, 1);
      #1;
      begin
        int c = k / 8;
        int b = 7 - (k % 8);
        int a = (off + c) & 16'h1FFF;
        logic [7:0] g = galt ? f_ga(a) : f_gn(a);
        int e = {f_blu(a)[b], g[b], f_red(a)[b]};
        if (!disp_en) chk("R7 blanked pixel", int'(pix_idx), 0);
        else          chk("R4 R9 pixel index", int'(pix_idx), e);
        if (k % 8 == 0) chk("R3 prefetch offset", int'(rd_off), (off + c + 1) & 16'h1FFF);
      end
    end
    if (upto == total) begin
      @(negedge clk);
      disp_en = 1'b1;
      #1;
      chk("R6 idle after row end", int'(pix_idx), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; row_start = 1'b0; ma = '0; ra = '0; char_count = '0;
    green_alt = 1'b0; disp_en = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset pixel", int'(pix_idx), 0);
    chk("R1 reset offset", int'(rd_off), 0);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 idle before row", int'(pix_idx), 0);
    // directed corners
    run_row(0, 0, 1, 1'b0, -1, 1'b0);
    run_row(14'h07FF, 0, 6, 1'b0, -1, 1'b0);    // R3 offset wraps past 0x1FFF
    run_row(14'h3ABC, 31, 3, 1'b1, -1, 1'b0);   // R2 masked sum, R5 alternate green
    run_row(5, 2, 0, 1'b0, -1, 1'b0);           // R6 empty row
    run_row(100, 7, 4, 1'b1, 11, 1'b0);         // R8 abort mid-row
    run_row(200, 3, 2, 1'b0, -1, 1'b0);
    run_row(14'h1234, 9, 5, 1'b0, -1, 1'b1);    // R7 random blanking
    // random rows
    for (int i = 0; i < 40; i++) begin
      run_row($urandom_range(0, 16383), $urandom_range(0, 31), $urandom_range(0, 24),
              1'($urandom_range(0, 1)),
              ($urandom_range(0, 7) == 0) ? $urandom_range(0, 30) : -1,
              1'($urandom_range(0, 1)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule